// File: doc/BRIEF.md
# Power-Save Clock Divider Register

This block holds a single 16-bit power-save control word that a host bus reaches at one fixed address. The word has an enable flag and a two-bit rate code. When the flag is set, the block slows the logic behind it to one of four rates. It does this by giving a one-cycle clock-enable strobe on the input clock, so no gated or derived clock is needed. When the flag is clear, or the code selects the undivided rate, the strobe stays high on every cycle.

The host writes the word with a write strobe and reads it back with a read strobe. Read data is combinational within the same bus cycle. Only the flag and the rate code are stored. Every other bit position reads back as zero. A write that changes the flag or the code restarts the internal phase counter, so the first slow strobe always comes after a whole slow period. A write that leaves both unchanged does not disturb the running cadence.

Top module: `psave_clk_divider`

## Requirements
- R1: A write updates the control word only when `bus_addr` equals the register address (default F0h). A write to any other address leaves the word unchanged.
- R2: While `bus_rd` is high and `bus_addr` equals the register address, `bus_rdata` shows the control word in the same cycle. In every other case `bus_rdata` is zero.
- R3: Bit 15 is the power-save enable and bits 1:0 are the rate code. Bits 14:2 read back as zero whatever value was written to them.
- R4: After reset the control word reads 0000h and `clk_en_o` is high on every cycle.
- R5: While the enable bit is 0, `clk_en_o` is high on every cycle, whatever the rate code holds.
- R6: With the enable bit set and rate code 00, `clk_en_o` is high on every cycle.
- R7: With the enable bit set, rate codes 01, 10 and 11 make `clk_en_o` high for one cycle out of every 4, 8 and 16 cycles respectively.
- R8: A write that changes the enable bit or the rate code restarts the cadence. If the clock edge that takes the write is edge k, `clk_en_o` is first high in the cycle after edge k+N-1, and then every N cycles. No shortened or merged strobe is produced.
- R9: A write to the register that leaves the enable bit and the rate code unchanged does not shift the strobe cadence. This holds even when the reserved bits of the written data differ.
- R10: A write that clears the enable bit makes `clk_en_o` high from the cycle right after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Host bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| clk_en_o | output | 1 | Clock-enable strobe for the slowed logic |

## Verification
Read data is combinational, so the bench checks it one time step after it drives the read strobe and address, inside the same cycle. A register write takes effect at the first rising edge after it is driven. The bench counts strobe cycles from that edge: sample j is taken mid-cycle after edge k+j-1, and the strobe is expected exactly when j plus any carried phase is a multiple of the effective ratio. All four codes are swept with the enable both set and clear. The full-rate return after a disable is expected at the very first sample.

// File: rtl/psv_pkg.sv
package psv_pkg;

   // Width of the rate code; the slowest ratio is 2**(2**PSV_SEL_W).
   localparam int unsigned PSV_SEL_W = 2;
   // Counter width that covers the slowest ratio minus one.
   localparam int unsigned PSV_CNT_W = 1 << PSV_SEL_W;

   typedef logic [PSV_SEL_W-1:0] psv_sel_t;
   typedef logic [PSV_CNT_W-1:0] psv_cnt_t;

   typedef struct packed {
      logic     en;
      psv_sel_t sel;
   } psv_ctrl_t;

   // Last phase value in a slow period: code c>0 gives ratio 2**(c+1).
   function automatic psv_cnt_t psv_last_phase(psv_sel_t sel);
      logic [31:0] ratio;
      ratio = 32'd1 << (32'(sel) + 32'd1);
      return psv_cnt_t'(ratio - 32'd1);
   endfunction

endpackage

// File: rtl/psv_bus_decode.sv
module psv_bus_decode
   import psv_pkg::*;
#(
   parameter int unsigned           ADDR_W   = 8,
   parameter int unsigned           DATA_W   = 16,
   parameter int unsigned           EN_POS   = 15,
   parameter logic [ADDR_W-1:0]     REG_ADDR = 'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   input  psv_ctrl_t         ctrl_q,
   output logic              wr_hit,
   output psv_ctrl_t         ctrl_wr,
   output logic [DATA_W-1:0] bus_rdata
);

   logic              addr_hit;
   logic [DATA_W-1:0] rd_word;
   logic              wdata_unused;

   initial begin
      assert (EN_POS < DATA_W) else $error("enable bit outside data word");
      assert (EN_POS > PSV_SEL_W) else $error("enable bit overlaps rate code");
   end

   assign addr_hit = (bus_addr == REG_ADDR);
   assign wr_hit   = bus_wr && addr_hit;

   assign ctrl_wr.en  = bus_wdata[EN_POS];
   assign ctrl_wr.sel = bus_wdata[PSV_SEL_W-1:0];

   // Reserved bits of the write word are dropped.
   generate
      if (EN_POS + 1 < DATA_W) begin : g_hi_rsv
         assign wdata_unused = ^{bus_wdata[DATA_W-1:EN_POS+1],
                                 bus_wdata[EN_POS-1:PSV_SEL_W]};
      end else begin : g_no_hi_rsv
         assign wdata_unused = ^bus_wdata[EN_POS-1:PSV_SEL_W];
      end
   endgenerate

   // Build the read word bit by bit; reserved positions tie to zero.
   generate
      for (genvar b = 0; b < DATA_W; b++) begin : g_rd
         if (b == EN_POS) begin : g_en
            assign rd_word[b] = ctrl_q.en;
         end else if (b < PSV_SEL_W) begin : g_sel
            assign rd_word[b] = ctrl_q.sel[b];
         end else begin : g_rsv
            assign rd_word[b] = 1'b0;
         end
      end
   endgenerate

   assign bus_rdata = (bus_rd && addr_hit) ? rd_word : '0;

   // R2
   rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_rd && addr_hit) |-> (bus_rdata == '0));

   // R3
   rsv_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[EN_POS-1:PSV_SEL_W] == '0);

endmodule

// File: rtl/psv_ctrl_reg.sv
module psv_ctrl_reg
   import psv_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_hit,
   input  psv_ctrl_t ctrl_wr,
   output psv_ctrl_t ctrl_q,
   output logic      restart
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_hit) begin
         ctrl_q <= ctrl_wr;
      end
   end

   // Only a change of the stored fields realigns the slow cadence.
   assign restart = wr_hit && (ctrl_wr != ctrl_q);

   // R1
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(ctrl_q));

endmodule

// File: rtl/psv_pulse_gen.sv
module psv_pulse_gen
   import psv_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  psv_ctrl_t ctrl_q,
   input  logic      restart,
   output logic      clk_en_o
);

   psv_cnt_t phase_q;
   psv_cnt_t last_w;
   logic     bypass;
   logic     at_last;

   assign last_w  = psv_last_phase(ctrl_q.sel);
   assign bypass  = !ctrl_q.en || (ctrl_q.sel == '0);
   assign at_last = (phase_q == last_w);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (restart || bypass || at_last) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + psv_cnt_t'(1);
      end
   end

   assign clk_en_o = bypass || at_last;

   // R7
   slow_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_o && !bypass && !restart) |=> !clk_en_o);

   // R8
   restart_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (bypass || !clk_en_o));

   // R6
   div1_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.en && ctrl_q.sel == '0) |-> clk_en_o);

endmodule

// File: rtl/psave_clk_divider.sv
module psave_clk_divider
   import psv_pkg::*;
#(
   parameter int unsigned       ADDR_W   = 8,
   parameter int unsigned       DATA_W   = 16,
   parameter int unsigned       EN_POS   = 15,
   parameter logic [ADDR_W-1:0] REG_ADDR = 'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              clk_en_o
);

   psv_ctrl_t ctrl_q;
   psv_ctrl_t ctrl_wr;
   logic      wr_hit;
   logic      restart;

   psv_bus_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .EN_POS   (EN_POS),
      .REG_ADDR (REG_ADDR)
   ) i_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .ctrl_q    (ctrl_q),
      .wr_hit    (wr_hit),
      .ctrl_wr   (ctrl_wr),
      .bus_rdata (bus_rdata)
   );

   psv_ctrl_reg i_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hit  (wr_hit),
      .ctrl_wr (ctrl_wr),
      .ctrl_q  (ctrl_q),
      .restart (restart)
   );

   psv_pulse_gen i_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_q   (ctrl_q),
      .restart  (restart),
      .clk_en_o (clk_en_o)
   );

   // R5
   disabled_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q.en |-> clk_en_o);

   // R10
   disable_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !ctrl_wr.en) |=> clk_en_o);

endmodule

// File: tb/test_psave_clk_divider.sv
`timescale 1ns/1ps
module test_psave_clk_divider;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        clk_en_o;

   int n_chk = 0;
   int n_fail = 0;

   localparam logic [7:0]  REG_A   = 8'hF0;
   localparam logic [15:0] KEEP_M  = 16'h8003;

   always #2 clk = ~clk;

   psave_clk_divider i_psave_clk_divider (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .clk_en_o  (clk_en_o)
   );

   function automatic int ratio_of(logic en, logic [1:0] code);
      if (!en || code == 2'd0) return 1;
      return 1 << (int'(code) + 1);
   endfunction

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Edge k takes the write; returns at the negedge after edge k.
   task automatic bus_write(logic [7:0] a, logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read_chk(string req, logic [7:0] a, logic rd, logic [15:0] exp);
      @(negedge clk);
      bus_addr = a; bus_rd = rd;
      #1;
      chk(req, bus_rdata, exp, "read data");
      bus_rd = 1'b0;
   endtask

   // Sample j taken mid-cycle after edge k+j-1; strobe when (j+phase)%n==0.
   task automatic pulse_run(string req, int n, int cycles, int phase);
      for (int j = 1; j <= cycles; j++) begin
         if (j > 1) @(negedge clk);
         #1;
         chk(req, 16'(clk_en_o), 16'(((j + phase) % n) == 0), "clk_en");
      end
   endtask

   initial begin
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4: reset state
      bus_read_chk("R4", REG_A, 1'b1, 16'h0000);
      pulse_run("R4", 1, 5, 0);

      // R7, R8, R5, R6: sweep every code with enable clear then set
      for (int en = 0; en < 2; en++) begin
         for (int c = 0; c < 4; c++) begin
            logic [15:0] w;
            string tag;
            w = {en[0], 13'h0, c[1:0]};
            tag = (en == 0) ? "R5" : ((c == 0) ? "R6" : "R8");
            bus_write(REG_A, w);
            pulse_run(tag, ratio_of(en[0], c[1:0]), 40, 0);
            bus_read_chk("R2", REG_A, 1'b1, w);
         end
      end

      // R3: reserved bits read zero after all-ones write
      bus_write(REG_A, 16'hFFFF);
      bus_read_chk("R3", REG_A, 1'b1, KEEP_M);
      bus_write(REG_A, 16'h5A5D);
      bus_read_chk("R3", REG_A, 1'b1, 16'h5A5D & KEEP_M);

      // R1: writes elsewhere ignored
      bus_write(REG_A, 16'h8002);
      bus_write(8'hF2, 16'h0001);
      bus_write(8'h70, 16'h0003);
      bus_read_chk("R1", REG_A, 1'b1, 16'h8002);

      // R2: other address or no strobe reads zero
      bus_read_chk("R2", 8'hF1, 1'b1, 16'h0000);
      bus_read_chk("R2", REG_A, 1'b0, 16'h0000);

      // R9: rewriting same fields keeps cadence
      bus_write(REG_A, 16'h8003);
      pulse_run("R7", 16, 6, 0);
      bus_write(REG_A, 16'hFFFF);
      pulse_run("R9", 16, 40, 7);

      // R10: clearing enable gives full rate at once
      bus_write(REG_A, 16'h8001);
      pulse_run("R7", 4, 6, 0);
      bus_write(REG_A, 16'h0003);
      pulse_run("R10", 1, 10, 0);

      // R8: switching between slow codes restarts
      bus_write(REG_A, 16'h8003);
      pulse_run("R8", 16, 5, 0);
      bus_write(REG_A, 16'h8002);
      pulse_run("R8", 8, 20, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule